// File: doc/BRIEF.md
# Two-Wire Register Slave with Indexed and Block Access

This block is a serial slave on a two-wire bus: a clock line driven by the host and an open-drain data line. Through it a host controller reads and writes a bank of 8-bit configuration registers that sit outside the block. Both bus lines are sampled with the system clock. The block finds start, repeated-start and stop conditions. It accepts the bytes that carry its own fixed address and ignores all other traffic. It pulls the data line low for acknowledges and for zero bits of read data.

After the address, the host sends a command byte, and its top bit picks the mode. In indexed mode the low seven bits of the command name a single register, which is then written or read. In block mode the host writes a length byte followed by data, or reads back a length byte followed by data. Both block directions always start at register zero and move upward. The register bank is reached through a parallel port. A write strobe carries an index and a byte. A read index is matched by read data returned in the same cycle.

Top module: `smb_regslave`

## Requirements
- R1: The block acknowledges the address byte D2h (write) and D3h (read), using bits 7:1 = 1101001. With any other address it never pulls the data line low and writes nothing until the next start or stop.
- R2: A command byte with bit 7 = 1 selects indexed mode. Bits 6:0 are the register index, and a following data byte is written to that register.
- R3: An indexed read is a write of address and command, a repeated start, and the read address. It returns the register at the index, most significant bit first.
- R4: A command byte with bit 7 = 0 selects block mode. A block write sends a length byte and then data bytes, which go to registers 0, 1, 2 and so on in order.
- R5: A block read first returns the number of implemented registers (8 by default) and then the registers starting from index 0.
- R6: Data bytes past the block length, bytes for an index at or beyond the register count, and bytes after the single indexed byte are all acknowledged and then discarded. A read from an index at or beyond the register count returns FFh.
- R7: A stop after any complete byte ends the transfer. Registers written before the stop keep their values, no further write takes place, and the data line is released.
- R8: Each accepted data byte causes exactly one write strobe, one cycle wide. The strobe comes at the end of the acknowledge clock that follows the byte.
- R9: The block pulls the data line low only while the clock line is low. It releases the line after the acknowledge clock and after the last bit of a read byte.
- R10: During and just after reset the data line is released and no write strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_we | output | 1 | One-cycle write strobe to the register bank |
| reg_waddr | output | AW (3) | Register index for the write |
| reg_wdata | output | 8 | Byte to be written |
| reg_raddr | output | AW (3) | Register index for the read |
| reg_rdata | input | 8 | Register contents for reg_raddr, same cycle |

## Verification
The hardest case to reach is a transfer that ends partway. Examples are a stop after two bytes of a longer announced block, and data that runs past the length or past the last register. In both cases the host must keep clocking bytes that the slave acknowledges and then drops. The bench's bus master is built from start, bit and stop tasks, so it can write any length byte, follow it with a different number of data bytes, and stop wherever the test requires. The registers are then read back through the bus, so any stray or missing write shows up at the ports.

// File: rtl/smb_pkg.sv
package smb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_CMD,
        BK_COUNT,
        BK_DATA
    } byte_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    typedef struct packed {
        logic       blk;
        logic [6:0] index;
    } cmd_t;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] own);
        return b[7:1] == own;
    endfunction

    function automatic cmd_t decode_cmd(input logic [7:0] b);
        cmd_t c;
        c.blk   = ~b[7];
        c.index = b[6:0];
        return c;
    endfunction

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond
    import smb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_in,
    input  logic     sda_in,
    output line_ev_t ev
);
    logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
    logic scl_d, sda_d;
    logic scl_now, sda_now;

    assign scl_now = scl_sh[SYNC_STAGES-1];
    assign sda_now = sda_sh[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_in};
            sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_in};
            scl_d  <= scl_now;
            sda_d  <= sda_now;
        end
    end

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_d;
        ev.scl_fall = ~scl_now & scl_d;
        ev.start    = scl_now & scl_d & sda_d & ~sda_now;
        ev.stop     = scl_now & scl_d & ~sda_d & sda_now;
    end

endmodule

// File: rtl/smb_proto.sv
module smb_proto
    import smb_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] SLV_ADDR = 7'h69,
    parameter int         AW       = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  line_ev_t      ev,
    output logic          sda_oe,
    output logic          reg_we,
    output logic [AW-1:0] reg_waddr,
    output logic [7:0]    reg_wdata,
    output logic [AW-1:0] reg_raddr,
    input  logic [7:0]    reg_rdata
);
    localparam logic [7:0] REG_CNT = 8'(NUM_REGS);

    bus_state_e st;
    byte_kind_e kind;
    logic [3:0] bitcnt;
    logic [7:0] shreg, txsh, ptr, remain;
    logic       is_read, nacked;
    cmd_t       cmd;

    logic [7:0] tx_data, ptr_inc;
    logic       wr_ok;

    assign reg_raddr = ptr[AW-1:0];
    assign tx_data   = (ptr < REG_CNT) ? reg_rdata : 8'hFF;
    assign ptr_inc   = (ptr == 8'hFF) ? ptr : ptr + 8'd1;
    assign wr_ok     = (remain != 8'd0) && (ptr < REG_CNT);

    always_ff @(posedge clk) begin
        reg_we <= 1'b0;
        if (rst) begin
            st        <= ST_IDLE;
            kind      <= BK_ADDR;
            bitcnt    <= '0;
            shreg     <= '0;
            txsh      <= '0;
            ptr       <= '0;
            remain    <= '0;
            is_read   <= 1'b0;
            nacked    <= 1'b0;
            cmd       <= '0;
            sda_oe    <= 1'b0;
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else if (ev.start) begin
            st     <= ST_RX;
            kind   <= BK_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            st     <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            case (st)
                ST_RX: begin
                    if (ev.scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        bitcnt <= '0;
                        case (kind)
                            BK_ADDR: begin
                                if (addr_hit(shreg, SLV_ADDR)) begin
                                    is_read <= shreg[0];
                                    sda_oe  <= 1'b1;
                                    st      <= ST_RX_ACK;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end
                            BK_CMD: begin
                                cmd    <= decode_cmd(shreg);
                                ptr    <= shreg[7] ? {1'b0, shreg[6:0]} : 8'd0;
                                remain <= shreg[7] ? 8'd1 : 8'd0;
                                sda_oe <= 1'b1;
                                st     <= ST_RX_ACK;
                            end
                            BK_COUNT: begin
                                remain <= shreg;
                                sda_oe <= 1'b1;
                                st     <= ST_RX_ACK;
                            end
                            default: begin
                                sda_oe <= 1'b1;
                                st     <= ST_RX_ACK;
                            end
                        endcase
                    end
                end
                ST_RX_ACK: begin
                    if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        case (kind)
                            BK_ADDR: begin
                                if (is_read) begin
                                    st     <= ST_TX;
                                    bitcnt <= '0;
                                    if (cmd.blk) begin
                                        txsh   <= REG_CNT;
                                        sda_oe <= ~REG_CNT[7];
                                    end else begin
                                        txsh   <= tx_data;
                                        sda_oe <= ~tx_data[7];
                                        ptr    <= ptr_inc;
                                    end
                                end else begin
                                    st   <= ST_RX;
                                    kind <= BK_CMD;
                                end
                            end
                            BK_CMD: begin
                                st   <= ST_RX;
                                kind <= cmd.blk ? BK_COUNT : BK_DATA;
                            end
                            BK_COUNT: begin
                                st   <= ST_RX;
                                kind <= BK_DATA;
                            end
                            default: begin
                                st <= ST_RX;
                                if (wr_ok) begin
                                    reg_we    <= 1'b1;
                                    reg_waddr <= ptr[AW-1:0];
                                    reg_wdata <= shreg;
                                    ptr       <= ptr_inc;
                                end
                                if (remain != 8'd0) remain <= remain - 8'd1;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (ev.scl_rise) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            st     <= ST_TX_ACK;
                        end else begin
                            txsh   <= {txsh[6:0], 1'b0};
                            sda_oe <= ~txsh[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (ev.scl_rise) begin
                        nacked <= ev.sda;
                    end else if (ev.scl_fall) begin
                        if (nacked) begin
                            st <= ST_IGNORE;
                        end else begin
                            st     <= ST_TX;
                            bitcnt <= '0;
                            txsh   <= tx_data;
                            sda_oe <= ~tx_data[7];
                            ptr    <= ptr_inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_DRIVE_ONLY_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl); // R9
    AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IGNORE) |-> !sda_oe); // R1
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we); // R8
    AST_WE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(ev.scl_fall)); // R8
    AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe); // R7
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && !reg_we)); // R10

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_pkg::*;
#(
    parameter int         NUM_REGS = 8,
    parameter logic [6:0] SLV_ADDR = 7'h69,
    localparam int        AW       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_in,
    input  logic          sda_in,
    output logic          sda_oe,
    output logic          reg_we,
    output logic [AW-1:0] reg_waddr,
    output logic [7:0]    reg_wdata,
    output logic [AW-1:0] reg_raddr,
    input  logic [7:0]    reg_rdata
);
    line_ev_t ev;

    smb_line_cond #(.SYNC_STAGES(2)) u_line (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    smb_proto #(
        .NUM_REGS (NUM_REGS),
        .SLV_ADDR (SLV_ADDR),
        .AW       (AW)
    ) u_proto (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: tb/smb_regslave_test.sv
module smb_regslave_test;
    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_line;
    logic       sda_oe, reg_we;
    logic [2:0] reg_waddr, reg_raddr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] rf [8];
    logic [7:0] exp_rf [8];
    logic [7:0] wbuf [12];
    logic [7:0] rbuf [12];
    int nvec = 0, nfail = 0, wecount = 0, bad_drive = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = rf[reg_raddr];

    smb_regslave uut (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .sda_oe    (sda_oe),
        .reg_we    (reg_we),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) rf[i] <= 8'h00;
        end else if (reg_we) begin
            rf[reg_waddr] <= reg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        oe_prev <= sda_oe;
        if (reg_we) wecount <= wecount + 1;
        if (sda_oe && !oe_prev && m_scl) bad_drive <= bad_drive + 1;
    end

    // {index, data}
    localparam logic [15:0] VEC [6] = '{16'h005A, 16'h07A5, 16'h033C,
                                        16'h0581, 16'h01FF, 16'h0300};

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; q();
        m_scl = 1'b1; q();
        m_sda = 1'b0; q();
        m_scl = 1'b0; q();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; q();
        m_scl = 1'b1; q();
        m_sda = 1'b1; q(); q();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; q();
        m_scl = 1'b1; q(); q();
        m_scl = 1'b0; q();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; q();
        m_scl = 1'b1; q();
        b = sda_line; q();
        m_scl = 1'b0; q();
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) get_bit(d[i]);
        put_bit(~give_ack);
    endtask

    task automatic idx_write(input logic [7:0] addr, input logic [6:0] idx,
                             input logic [7:0] d, output logic [2:0] acks);
        bus_start();
        wr_byte(addr, acks[2]);
        wr_byte({1'b1, idx}, acks[1]);
        wr_byte(d, acks[0]);
        bus_stop();
    endtask

    task automatic idx_read(input logic [6:0] idx, output logic [7:0] d,
                            output logic [2:0] acks);
        bus_start();
        wr_byte(8'hD2, acks[2]);
        wr_byte({1'b1, idx}, acks[1]);
        bus_start();
        wr_byte(8'hD3, acks[0]);
        rd_byte(1'b0, d);
        bus_stop();
    endtask

    task automatic blk_write(input logic [7:0] len, input int n, output int nacks);
        logic a;
        nacks = 0;
        bus_start();
        wr_byte(8'hD2, a); nacks += a;
        wr_byte(8'h00, a); nacks += a;
        wr_byte(len, a);   nacks += a;
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], a); nacks += a;
        end
        bus_stop();
    endtask

    task automatic blk_read(input int n);
        logic a;
        bus_start();
        wr_byte(8'hD2, a);
        wr_byte(8'h00, a);
        bus_start();
        wr_byte(8'hD3, a);
        for (int i = 0; i < n; i++) rd_byte(i < n - 1, rbuf[i]);
        bus_stop();
    endtask

    task automatic check_all_blk(input string req);
        blk_read(9);
        chk({req, " length byte"}, rbuf[0], 8);
        for (int i = 0; i < 8; i++) chk({req, " block data"}, rbuf[i+1], exp_rf[i]);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d;
        int nk, we0;

        for (int i = 0; i < 8; i++) exp_rf[i] = 8'h00;
        repeat (5) @(negedge clk);
        // R10: quiet during reset
        chk("R10 oe in reset", sda_oe, 0);
        chk("R10 we in reset", reg_we, 0);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10 oe after reset", sda_oe, 0);

        // R2 / R3 / R8: indexed write then read-back vectors
        for (int v = 0; v < 6; v++) begin
            we0 = wecount;
            idx_write(8'hD2, VEC[v][14:8], VEC[v][7:0], acks);
            chk("R2 indexed write acks", acks, 3'b111);
            chk("R8 one strobe per byte", wecount - we0, 1);
            exp_rf[VEC[v][10:8]] = VEC[v][7:0];
            idx_read(VEC[v][14:8], d, acks);
            chk("R1 read address acks", acks, 3'b111);
            chk("R3 indexed read data", d, VEC[v][7:0]);
        end

        // R4 / R5: block write of 4, block read of all
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        we0 = wecount;
        blk_write(8'd4, 4, nk);
        chk("R4 block write acks", nk, 7);
        chk("R8 block strobes", wecount - we0, 4);
        for (int i = 0; i < 4; i++) exp_rf[i] = wbuf[i];
        check_all_blk("R5");

        // R6: bytes past the length are acked and dropped
        wbuf[0] = 8'h91; wbuf[1] = 8'h92; wbuf[2] = 8'h93; wbuf[3] = 8'h94;
        blk_write(8'd2, 4, nk);
        chk("R6 past-length acks", nk, 7);
        exp_rf[0] = 8'h91; exp_rf[1] = 8'h92;
        check_all_blk("R6 past length");

        // R6: bytes past the last register are acked and dropped
        for (int i = 0; i < 10; i++) wbuf[i] = 8'hB0 + 8'(i);
        we0 = wecount;
        blk_write(8'd10, 10, nk);
        chk("R6 past-end acks", nk, 13);
        chk("R6 past-end strobes", wecount - we0, 8);
        for (int i = 0; i < 8; i++) exp_rf[i] = wbuf[i];
        check_all_blk("R6 past end");

        // R7: stop after two bytes of an announced five
        wbuf[0] = 8'hE1; wbuf[1] = 8'hE2;
        blk_write(8'd5, 2, nk);
        chk("R7 early stop acks", nk, 5);
        chk("R7 line released after stop", sda_line, 1);
        exp_rf[0] = 8'hE1; exp_rf[1] = 8'hE2;
        idx_read(7'd2, d, acks);
        chk("R7 untouched register", d, exp_rf[2]);
        check_all_blk("R7");

        // R1: foreign address is ignored
        we0 = wecount;
        idx_write(8'hA4, 7'd2, 8'h77, acks);
        chk("R1 foreign address no acks", acks, 3'b000);
        chk("R1 foreign address no strobe", wecount - we0, 0);
        idx_read(7'd2, d, acks);
        chk("R1 register kept", d, exp_rf[2]);

        // R6: indexed access beyond the register count
        we0 = wecount;
        idx_write(8'hD2, 7'h40, 8'h55, acks);
        chk("R6 out-of-range write acks", acks, 3'b111);
        chk("R6 out-of-range no strobe", wecount - we0, 0);
        idx_read(7'h40, d, acks);
        chk("R6 out-of-range read", d, 8'hFF);
        check_all_blk("R6 out of range");

        // R9: never pulled low while clock high; released at the end
        chk("R9 drive only with clock low", bad_drive, 0);
        chk("R9 line released", sda_oe, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule